// File: doc/BRIEF.md
# Access Fault Classifier with Status Capture

This block sits beside the address path of a 24-bit processor bus. For every access it looks at the address, the direction, the size, whether the processor is in supervisor mode, and the page map entry that the translation logic has already fetched for that address. It sorts the access into one verdict: allowed, or one of four fault classes (unmapped page, user access to privileged space, user access to kernel space, user write to a write-protected page).

When an access faults, the block loads three 16-bit status registers that software reads later: a general status word carrying a class-and-direction code, a bus status word carrying a byte-lane code and the upper address bits, and a second bus status word carrying the lower address bits. A one-cycle bus error pulse goes to the processor, but only while error reporting is enabled. An allowed write to the clear-status location resets all three registers to their idle value of 0xFFFF. Verdicts and the pulse appear one clock after the access is presented.

Top module: `afc_top`

## Requirements
- R1: Synchronous reset (active high) sets all three status registers to 0xFFFF, clears the bus error output and result valid, and sets the class to allowed (0).
- R2: An access with address below 0x400000 whose map entry bits 14:13 are both zero is an unmapped-page fault (class 1), in both supervisor and user mode.
- R3: A supervisor access that is not an unmapped-page fault is allowed (class 0), whatever its address or write-protect bit.
- R4: A user access at address 0x400000 or above is a privileged-space fault (class 2).
- R5: A user access below 0x400000 whose address bits 22:19 are all zero is a kernel-space fault (class 3).
- R6: A user write to a mapped page whose map entry bit 15 is clear is a write-protect fault (class 4); a user read of that page, and a user write when bit 15 is set, are allowed.
- R7: On an unmapped-page fault the general status becomes 0x8BFF for a write and 0xCBFF for a read; on a privileged-space fault it becomes 0x9AFF for a write and 0xDAFF for a read; bit 10 (0x0400) is also set when parity interrupt enable is high.
- R8: Kernel-space and write-protect faults leave the general status register unchanged.
- R9: On any fault bus status 0 becomes a lane code ORed with address bits 23:16 in its low byte: 0x7C00 for word (size 1) or long (size 2) accesses, 0x7E00 for a byte (size 0) at an odd address, 0x7D00 for a byte at an even address.
- R10: On any fault bus status 1 becomes address bits 15:0.
- R11: The bus error output is high for exactly the cycle after a faulting access when error enable is high, and stays low when it is low; status capture happens either way.
- R12: An allowed write whose address bits 23:22 are 01 and bits 19:16 are 0xC sets all three status registers to 0xFFFF; an allowed read of that address, or an allowed access elsewhere, changes no status register.
- R13: The checks apply in priority order unmapped page, supervisor allow, privileged space, kernel space, write protect; a user access to an unmapped kernel-space page is reported as unmapped-page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Logical byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_super | input | 1 | Processor is in supervisor mode |
| map_entry | input | 16 | Page map entry for this address |
| err_en | input | 1 | Error reporting enable |
| par_irq_en | input | 1 | Parity interrupt enable, sets bit 10 of the general status code |
| res_valid | output | 1 | Verdict for the access of the previous cycle |
| res_class | output | 3 | Verdict: 0 allowed, 1 unmapped, 2 privileged, 3 kernel, 4 write protect |
| bus_err | output | 1 | One-cycle bus error pulse |
| gen_stat | output | 16 | General status register |
| bus_stat0 | output | 16 | Bus status register 0 (lane code and high address) |
| bus_stat1 | output | 16 | Bus status register 1 (low address) |

## Verification
The bound checker watches, cycle by cycle, that an unmapped low-zone access yields the unmapped verdict, that supervisor accesses to mapped space are allowed, that a bus error only follows an enabled access and carries the low address in bus status 1, that kernel and write-protect verdicts leave the general status untouched, and that an allowed write to the clear location idles all three registers. The exact status code values, the lane codes for odd and even bytes, the parity bit, the priority between overlapping checks and the silence of a read to the clear location are shown only by the bench's vector table and directed scenarios, which compare each register against values worked out from the requirements.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int ADDR_W = 24;
    localparam int STAT_W = 16;

    typedef enum logic [2:0] {
        CLS_OK     = 3'd0,
        CLS_UNMAP  = 3'd1,
        CLS_PRIV   = 3'd2,
        CLS_KERNEL = 3'd3,
        CLS_WPROT  = 3'd4
    } fault_cls_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_t;

    localparam logic [STAT_W-1:0] STAT_IDLE = 16'hFFFF;
    localparam logic [STAT_W-1:0] PAR_BIT   = 16'h0400;

    // Fields of the page map entry the classifier decodes.
    localparam int MAP_WE_BIT  = 15;
    localparam int MAP_PST_HI  = 14;
    localparam int MAP_PST_LO  = 13;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        acc_size_t         size;
    } acc_info_t;

    function automatic logic [STAT_W-1:0] gen_code(input fault_cls_t c,
                                                   input logic wr,
                                                   input logic par);
        logic [STAT_W-1:0] base;
        if (c == CLS_UNMAP) base = wr ? 16'h8BFF : 16'hCBFF;
        else                base = wr ? 16'h9AFF : 16'hDAFF;
        return par ? (base | PAR_BIT) : base;
    endfunction

    function automatic logic [STAT_W-1:0] lane_code(input acc_info_t a);
        logic [STAT_W-1:0] lane;
        if (a.size != SZ_BYTE) lane = 16'h7C00;
        else if (a.addr[0])    lane = 16'h7E00;
        else                   lane = 16'h7D00;
        return lane | {8'h00, a.addr[ADDR_W-1:16]};
    endfunction

endpackage

// File: rtl/afc_classify.sv
module afc_classify
    import afc_pkg::*;
#(
    parameter logic [3:0] CLR_SEL = 4'hC
) (
    input  acc_info_t   acc,
    input  logic        super_mode,
    input  logic [15:0] map_entry,
    output fault_cls_t  cls,
    output logic        clr_hit
);
    logic low_zone;
    logic mapped;
    logic kernel_area;
    logic io_zone_a;

    always_comb begin
        low_zone    = (acc.addr[ADDR_W-1:22] == 2'b00);
        mapped      = (map_entry[MAP_PST_HI:MAP_PST_LO] != 2'b00);
        kernel_area = (acc.addr[22:19] == 4'h0);
        io_zone_a   = (acc.addr[ADDR_W-1:22] == 2'b01);

        if (low_zone && !mapped)                  cls = CLS_UNMAP;
        else if (super_mode)                      cls = CLS_OK;
        else if (!low_zone)                       cls = CLS_PRIV;
        else if (kernel_area)                     cls = CLS_KERNEL;
        else if (acc.wr && !map_entry[MAP_WE_BIT]) cls = CLS_WPROT;
        else                                      cls = CLS_OK;

        clr_hit = io_zone_a && (acc.addr[19:16] == CLR_SEL)
                  && acc.wr && (cls == CLS_OK);
    end
endmodule

// File: rtl/afc_status.sv
module afc_status
    import afc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              clr,
    input  fault_cls_t        cls,
    input  acc_info_t         acc,
    input  logic              par_en,
    output logic [STAT_W-1:0] gen_q,
    output logic [STAT_W-1:0] bs0_q,
    output logic [STAT_W-1:0] bs1_q
);
    logic sets_gen;

    always_comb sets_gen = (cls == CLS_UNMAP) || (cls == CLS_PRIV);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            gen_q <= STAT_IDLE;
            bs0_q <= STAT_IDLE;
            bs1_q <= STAT_IDLE;
        end else if (fire) begin
            if (sets_gen) gen_q <= gen_code(cls, acc.wr, par_en);
            bs0_q <= lane_code(acc);
            bs1_q <= acc.addr[15:0];
        end
    end
endmodule

// File: rtl/afc_top.sv
module afc_top
    import afc_pkg::*;
#(
    parameter logic [3:0] CLR_SEL = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic              acc_super,
    input  logic [15:0]       map_entry,
    input  logic              err_en,
    input  logic              par_irq_en,
    output logic              res_valid,
    output logic [2:0]        res_class,
    output logic              bus_err,
    output logic [STAT_W-1:0] gen_stat,
    output logic [STAT_W-1:0] bus_stat0,
    output logic [STAT_W-1:0] bus_stat1
);
    acc_info_t  acc;
    fault_cls_t cls;
    logic       clr_hit;
    logic       is_fault;

    always_comb begin
        acc.addr = acc_addr;
        acc.wr   = acc_write;
        acc.size = acc_size_t'(acc_size);
        is_fault = acc_valid && (cls != CLS_OK);
    end

    afc_classify #(.CLR_SEL(CLR_SEL)) u_cls (
        .acc        (acc),
        .super_mode (acc_super),
        .map_entry  (map_entry),
        .cls        (cls),
        .clr_hit    (clr_hit)
    );

    afc_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .fire   (is_fault),
        .clr    (acc_valid && clr_hit),
        .cls    (cls),
        .acc    (acc),
        .par_en (par_irq_en),
        .gen_q  (gen_stat),
        .bs0_q  (bus_stat0),
        .bs1_q  (bus_stat1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_class <= CLS_OK;
            bus_err   <= 1'b0;
        end else begin
            res_valid <= acc_valid;
            res_class <= acc_valid ? cls : CLS_OK;
            bus_err   <= is_fault && err_en;
        end
    end
endmodule

// File: rtl/afc_checker.sv
module afc_checker (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [23:0] acc_addr,
    input logic        acc_write,
    input logic        acc_super,
    input logic [15:0] map_entry,
    input logic        err_en,
    input logic        res_valid,
    input logic [2:0]  res_class,
    input logic        bus_err,
    input logic [15:0] gen_stat,
    input logic [15:0] bus_stat0,
    input logic [15:0] bus_stat1
);
    logic unmapped_low;
    logic clr_loc;
    always_comb begin
        unmapped_low = (acc_addr < 24'h400000) && (map_entry[14:13] == 2'b00);
        clr_loc      = (acc_addr[23:22] == 2'b01) && (acc_addr[19:16] == 4'hC);
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (gen_stat == 16'hFFFF && bus_stat0 == 16'hFFFF
                 && bus_stat1 == 16'hFFFF && !bus_err && !res_valid));

    a_r2_unmapped: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && unmapped_low) |=> (res_valid && res_class == 3'd1));

    a_r3_super_ok: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_super && !unmapped_low) |=> (res_class == 3'd0));

    a_r8_gen_kept: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_class == 3'd3 || res_class == 3'd4)) |-> $stable(gen_stat));

    a_r10_low_addr: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_stat1 == $past(acc_addr[15:0])));

    a_r11_err_gated: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(err_en) && $past(acc_valid)));

    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_super && clr_loc) |=>
        (gen_stat == 16'hFFFF && bus_stat0 == 16'hFFFF && bus_stat1 == 16'hFFFF));
endmodule

bind afc_top afc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .acc_super (acc_super),
    .map_entry (map_entry),
    .err_en    (err_en),
    .res_valid (res_valid),
    .res_class (res_class),
    .bus_err   (bus_err),
    .gen_stat  (gen_stat),
    .bus_stat0 (bus_stat0),
    .bus_stat1 (bus_stat1)
);

// File: tb/sim_afc_top.sv
module sim_afc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    typedef struct packed {
        logic        sup;
        logic        wr;
        logic [1:0]  sz;
        logic [23:0] ad;
        logic [15:0] mp;
        logic [2:0]  cls;
    } vec_t;

    // sup, wr, size, addr, map, expected class
    localparam vec_t TBL [NVEC] = '{
        {1'b1, 1'b0, 2'd1, 24'h012345, 16'h0000, 3'd1},  // R2 supervisor unmapped
        {1'b0, 1'b1, 2'd0, 24'h080003, 16'h0000, 3'd1},  // R2 user unmapped write
        {1'b1, 1'b1, 2'd1, 24'h612344, 16'h2000, 3'd0},  // R3 supervisor I/O
        {1'b0, 1'b0, 2'd0, 24'h612344, 16'h2000, 3'd2},  // R4 user read priv
        {1'b0, 1'b1, 2'd2, 24'h812346, 16'hA000, 3'd2},  // R4 user write priv
        {1'b0, 1'b0, 2'd1, 24'h040010, 16'hA000, 3'd3},  // R5 kernel
        {1'b0, 1'b1, 2'd0, 24'h100101, 16'h2000, 3'd4},  // R6 write protect
        {1'b0, 1'b0, 2'd1, 24'h100100, 16'h2000, 3'd0},  // R6 read allowed
        {1'b0, 1'b1, 2'd1, 24'h100100, 16'hA000, 3'd0},  // R6 write enabled
        {1'b0, 1'b0, 2'd1, 24'h010000, 16'h0000, 3'd1},  // R13 unmapped beats kernel
        {1'b1, 1'b0, 2'd1, 24'h040010, 16'h4000, 3'd0}   // R3 supervisor kernel area
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic        acc_super = 1'b0;
    logic [15:0] map_entry = '0;
    logic        err_en = 1'b1;
    logic        par_irq_en = 1'b0;
    logic        res_valid;
    logic [2:0]  res_class;
    logic        bus_err;
    logic [15:0] gen_stat;
    logic [15:0] bus_stat0;
    logic [15:0] bus_stat1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_gen = 16'hFFFF;
    logic [15:0] m_b0  = 16'hFFFF;
    logic [15:0] m_b1  = 16'hFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    afc_top u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_size(acc_size), .acc_super(acc_super),
        .map_entry(map_entry), .err_en(err_en), .par_irq_en(par_irq_en),
        .res_valid(res_valid), .res_class(res_class), .bus_err(bus_err),
        .gen_stat(gen_stat), .bus_stat0(bus_stat0), .bus_stat1(bus_stat1)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected register model, written from R7, R9, R10 alone.
    task automatic model(input logic [2:0] cls, input logic wr,
                         input logic [1:0] sz, input logic [23:0] ad,
                         input logic par);
        logic [15:0] lane;
        if (cls == 3'd1) m_gen = (wr ? 16'h8BFF : 16'hCBFF) | (par ? 16'h0400 : 16'h0);
        if (cls == 3'd2) m_gen = (wr ? 16'h9AFF : 16'hDAFF) | (par ? 16'h0400 : 16'h0);
        if (cls != 3'd0) begin
            lane = (sz != 2'd0) ? 16'h7C00 : (ad[0] ? 16'h7E00 : 16'h7D00);
            m_b0 = lane | {8'h00, ad[23:16]};
            m_b1 = ad[15:0];
        end
    endtask

    task automatic access(input logic sup, input logic wr, input logic [1:0] sz,
                          input logic [23:0] ad, input logic [15:0] mp);
        @(negedge clk);
        acc_valid = 1'b1; acc_super = sup; acc_write = wr;
        acc_size = sz; acc_addr = ad; map_entry = mp;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic check_regs(input string req);
        check(req, "gen_stat",  {16'h0, gen_stat},  {16'h0, m_gen});
        check(req, "bus_stat0", {16'h0, bus_stat0}, {16'h0, m_b0});
        check(req, "bus_stat1", {16'h0, bus_stat1}, {16'h0, m_b1});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "gen_stat",  {16'h0, gen_stat},  32'hFFFF);
        check("R1", "bus_stat0", {16'h0, bus_stat0}, 32'hFFFF);
        check("R1", "bus_stat1", {16'h0, bus_stat1}, 32'hFFFF);
        check("R1", "bus_err",   {31'h0, bus_err},   32'h0);
        check("R1", "res_valid", {31'h0, res_valid}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            access(TBL[i].sup, TBL[i].wr, TBL[i].sz, TBL[i].ad, TBL[i].mp);
            model(TBL[i].cls, TBL[i].wr, TBL[i].sz, TBL[i].ad, 1'b0);
            check("R2-R6/R13 table", "res_class", {29'h0, res_class}, {29'h0, TBL[i].cls});
            check("R11 table", "bus_err", {31'h0, bus_err}, {31'h0, (TBL[i].cls != 3'd0)});
            check_regs("R7/R8/R9/R10 table");
        end

        // R11: pulse lasts one cycle
        access(1'b0, 1'b0, 2'd1, 24'h700000, 16'h0);
        model(3'd2, 1'b0, 2'd1, 24'h700000, 1'b0);
        check("R11", "bus_err pulse", {31'h0, bus_err}, 32'h1);
        @(negedge clk);
        check("R11", "bus_err after pulse", {31'h0, bus_err}, 32'h0);

        // R7 parity bit with page fault write and privileged read
        par_irq_en = 1'b1;
        access(1'b0, 1'b1, 2'd1, 24'h2ABCDE, 16'h8000);
        model(3'd1, 1'b1, 2'd1, 24'h2ABCDE, 1'b1);
        check_regs("R7 parity unmapped");
        access(1'b0, 1'b0, 2'd0, 24'hE00001, 16'h0);
        model(3'd2, 1'b0, 2'd0, 24'hE00001, 1'b1);
        check_regs("R7 parity priv");
        par_irq_en = 1'b0;

        // R11: disabled reporting still captures status
        err_en = 1'b0;
        access(1'b0, 1'b1, 2'd2, 24'h3F0010, 16'h0000);
        model(3'd1, 1'b1, 2'd2, 24'h3F0010, 1'b0);
        check("R11", "bus_err masked", {31'h0, bus_err}, 32'h0);
        check_regs("R11 capture");
        err_en = 1'b1;

        // R12: allowed read of clear location does nothing
        access(1'b1, 1'b0, 2'd1, 24'h4C0000, 16'h0);
        check("R12", "res_class read clr", {29'h0, res_class}, 32'h0);
        check_regs("R12 read no clear");

        // R12 / R4: user write to clear location is a privileged fault, no clear
        access(1'b0, 1'b1, 2'd1, 24'h4C0002, 16'h0);
        model(3'd2, 1'b1, 2'd1, 24'h4C0002, 1'b0);
        check("R4", "res_class user clr", {29'h0, res_class}, 32'h2);
        check_regs("R12 user write no clear");

        // R12: supervisor write clears all three
        access(1'b1, 1'b1, 2'd1, 24'h4C0000, 16'h0);
        m_gen = 16'hFFFF; m_b0 = 16'hFFFF; m_b1 = 16'hFFFF;
        check_regs("R12 clear");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule